// File: doc/BRIEF.md
# GF(2^128) Field Multiplier for GHASH

This block multiplies two 128-bit elements of GF(2^128) under the GHASH polynomial x^128 + x^7 + x^2 + x + 1. Both operands and the result use the bit-reflected layout: a 16-byte hash block is read as one big-endian 128-bit integer. Bit 127 of that integer holds the coefficient of x^0 and bit 0 holds the coefficient of x^127. Converting bytes to and from this layout, and preparing the hash key, are left to the surrounding logic.

Internally the operands are split into 64-bit halves. Three 64x64 carry-less products are formed: low by low, high by high, and the XOR of the halves by each other. They are combined Karatsuba-style into a 255-bit product. That product is shifted left by one bit to undo the reflection. It is then folded back to 128 bits in two phases, each of which shifts and XORs the 32-bit lanes. The three partial multipliers are iterative and handle STEP bits of their second operand per clock.

A caller pulses `start` together with both operands. The block raises `busy` and, a fixed number of cycles later, pulses `done` for one cycle with the result on `prod`. The result stays there until the next operation completes. Requests made while busy are dropped. The first operand can therefore be kept on the bus as the hash key while the second operand changes from one request to the next.

Top module: `gfm_mul`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `prod` is zero and `done` and `busy` are low.
- R2: For any operands, `prod` equals the GHASH field product of `op_a` and `op_b`. In each operand, bit 127 is the coefficient of x^0 and bit 0 is the coefficient of x^127, and the reduction polynomial is x^128 + x^7 + x^2 + x + 1.
- R3: If either operand is zero, the result is zero.
- R4: The field element one is 128'h8000_0000_0000_0000_0000_0000_0000_0000. Multiplying any value by it, on either side, returns that value unchanged.
- R5: The reduction folds x^128 correctly: op_a = 128'h1 (x^127) times op_b = 128'h4000_0000_0000_0000_0000_0000_0000_0000 (x) gives 128'hE100_0000_0000_0000_0000_0000_0000_0000.
- R6: `done` is high for exactly one cycle. It rises 64/STEP+1 rising edges after the edge that accepts `start` (9 edges for STEP = 8).
- R7: `busy` rises on the accepting edge and falls with `done`. A `start` seen while `busy` is high is ignored: it changes neither the result nor the number of `done` pulses.
- R8: `prod` does not change except on the cycle in which `done` is high.
- R9: The product is commutative: swapping `op_a` and `op_b` gives the same `prod`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiply; operands are sampled on the same edge |
| op_a | input | 128 | First operand, reflected layout (typically the hash key) |
| op_b | input | 128 | Second operand, reflected layout |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when `prod` holds a new result |
| prod | output | 128 | Registered field product |

## Verification
Random operand pairs are compared against a bit-serial shift-and-add field multiply written in the bench. That comparison separates a correct Karatsuba combination and reduction from errors in the middle-term placement, in the one-bit shift, or in any of the six lane shift amounts. Zero operands reveal any stray constant or lane feedback. The multiplicative identity on each side shows that bit order and reduction leave an unreduced value untouched. The single product x^127·x exercises the reduction path alone. Swapped operands check that the three partial products are symmetric. A second request raised mid-operation, followed by watching for extra pulses, tells dropping a request apart from restarting or queuing it.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int BLK_W  = 128;
  localparam int HALF_W = BLK_W / 2;
  localparam int LANE_W = 32;
  typedef logic [BLK_W-1:0]   blk_t;
  typedef logic [2*BLK_W-1:0] wide_t;
endpackage

// File: rtl/gfm_clmul64.sv
module gfm_clmul64 #(
  parameter int HW   = 64,
  parameter int STEP = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [HW-1:0]   x,
  input  logic [HW-1:0]   y,
  output logic            vld,
  output logic [2*HW-1:0] prod
);
  localparam int NSTEP = HW / STEP;
  localparam int CW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  logic [2*HW-1:0] xs, acc, part;
  logic [HW-1:0]   ys;
  logic [CW-1:0]   cnt;
  logic            run;

  always_comb begin
    part = '0;
    for (int j = 0; j < STEP; j++) begin
      if (ys[j]) part = part ^ (xs << j);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xs  <= '0;
      ys  <= '0;
      acc <= '0;
      cnt <= '0;
      run <= 1'b0;
      vld <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (go) begin
        xs  <= {{HW{1'b0}}, x};
        ys  <= y;
        acc <= '0;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        acc <= acc ^ part;
        xs  <= xs << STEP;
        ys  <= ys >> STEP;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NSTEP - 1)) begin
          run <= 1'b0;
          vld <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;

  // R7: the controller never restarts a partial product that is still running
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst) go |-> !run);
  // R6: the completion strobe lasts one cycle
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst) vld |=> !vld);
endmodule

// File: rtl/gfm_reduce.sv
module gfm_reduce
  import gfm_pkg::*;
#(
  parameter int W    = BLK_W,
  parameter int LANE = LANE_W
) (
  input  logic [2*W-1:0] wide,
  output logic [W-1:0]   res
);
  localparam int NL = W / LANE;
  localparam int L1 = 31, L2 = 30, L3 = 25;
  localparam int R1S = 1, R2S = 2, R3S = 7;

  logic [W-1:0] lo, hi, t, lo1, keep, s, lo2;

  assign lo = wide[W-1:0];
  assign hi = wide[2*W-1:W];

  for (genvar l = 0; l < NL; l++) begin : g_ph1
    logic [LANE-1:0] ln;
    assign ln = lo[l*LANE +: LANE];
    assign t[l*LANE +: LANE] = (ln << L1) ^ (ln << L2) ^ (ln << L3);
  end

  assign lo1  = lo ^ (t << (W - LANE));
  assign keep = t >> LANE;

  for (genvar l = 0; l < NL; l++) begin : g_ph2
    logic [LANE-1:0] ln;
    assign ln = lo1[l*LANE +: LANE];
    assign s[l*LANE +: LANE] = (ln >> R1S) ^ (ln >> R2S) ^ (ln >> R3S) ^ keep[l*LANE +: LANE];
  end

  assign lo2 = lo1 ^ s;
  assign res = hi ^ lo2;
endmodule

// File: rtl/gfm_mul.sv
module gfm_mul
  import gfm_pkg::*;
#(
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [127:0] op_a,
  input  logic [127:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [127:0] prod
);
  localparam int HW = HALF_W;

  logic              go;
  logic [HW-1:0]     xin [3];
  logic [HW-1:0]     yin [3];
  logic [2*HW-1:0]   pr  [3];
  logic [2:0]        vld;
  logic [2*HW-1:0]   mid;
  wide_t             full, shifted;
  blk_t              reduced;

  assign go = start & ~busy;

  assign xin[0] = op_a[HW-1:0];
  assign xin[1] = op_a[2*HW-1:HW];
  assign xin[2] = op_a[HW-1:0] ^ op_a[2*HW-1:HW];
  assign yin[0] = op_b[HW-1:0];
  assign yin[1] = op_b[2*HW-1:HW];
  assign yin[2] = op_b[HW-1:0] ^ op_b[2*HW-1:HW];

  for (genvar k = 0; k < 3; k++) begin : g_part
    gfm_clmul64 #(.HW(HW), .STEP(STEP)) u_cl (
      .clk (clk),
      .rst (rst),
      .go  (go),
      .x   (xin[k]),
      .y   (yin[k]),
      .vld (vld[k]),
      .prod(pr[k])
    );
  end

  // Karatsuba recombination, then one-bit shift for reflected order
  assign mid     = pr[2] ^ pr[0] ^ pr[1];
  assign full    = {pr[1], pr[0]} ^ ({{(2*BLK_W-2*HW){1'b0}}, mid} << HW);
  assign shifted = full << 1;

  gfm_reduce #(.W(BLK_W), .LANE(LANE_W)) u_red (
    .wide(shifted),
    .res (reduced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= 1'b0;
      if (go) busy <= 1'b1;
      if (vld[0]) begin
        prod <= reduced;
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_busy_on_accept_r7: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_prod_hold_r8: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(prod));
  p_parts_aligned_r2: assert property (@(posedge clk) disable iff (rst) (vld[0] == vld[1]) && (vld[0] == vld[2]));
  p_idle_no_result_r7: assert property (@(posedge clk) disable iff (rst) !busy |-> !vld[0]);
endmodule

// File: tb/sim_gfm_mul.sv
module sim_gfm_mul;
  localparam int STEP = 8;
  localparam int LAT  = 64 / STEP + 1;
  localparam logic [127:0] ONE = {1'b1, 127'b0};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic         busy, done;
  logic [127:0] prod;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gfm_mul #(.STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod(prod)
  );

  function automatic logic [127:0] gf_ref(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0;
    logic [127:0] v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'hE1, 120'b0};
      else      v = v >> 1;
    end
    return z;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one request and wait for done; checks latency (R6) and pulse width
  task automatic run(input logic [127:0] a, input logic [127:0] b, output logic [127:0] res);
    int lat = 0;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 latency", 128'(lat), 128'(LAT));
    res = prod;
    @(negedge clk);
    chk("R6 done width", {127'b0, done}, 128'b0);
  endtask

  task automatic t_reset();
    chk("R1 prod", prod, '0);
    chk("R1 done", {127'b0, done}, '0);
    chk("R1 busy", {127'b0, busy}, '0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 prod after", prod, '0);
    chk("R1 busy after", {127'b0, busy}, '0);
  endtask

  task automatic t_zero();
    logic [127:0] r;
    run('0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, r); chk("R3 zero a", r, '0);
    run(128'hdead_beef_0000_1111_2222_3333_4444_5555, '0, r); chk("R3 zero b", r, '0);
  endtask

  task automatic t_identity();
    logic [127:0] r;
    logic [127:0] v = 128'h66e9_4bd4_ef8a_2c3b_884c_fa59_ca34_2b2e;
    run(ONE, v, r); chk("R4 one*v", r, v);
    run(v, ONE, r); chk("R4 v*one", r, v);
  endtask

  task automatic t_poly();
    logic [127:0] r;
    run(128'h1, {2'b01, 126'b0}, r);
    chk("R5 x127*x", r, {8'hE1, 120'b0});
  endtask

  task automatic t_random();
    logic [127:0] r, r2, a, b;
    for (int n = 0; n < 24; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      run(a, b, r);
      chk("R2 random", r, gf_ref(a, b));
      if (n < 4) begin
        run(b, a, r2);
        chk("R9 swap", r2, r);
      end
    end
  endtask

  task automatic t_busy_ignore();
    logic [127:0] a = 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321;
    logic [127:0] b = 128'hcafe_f00d_1357_9bdf_2468_ace0_5555_aaaa;
    logic [127:0] held;
    int pulses = 0;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    chk("R7 busy set", {127'b0, busy}, 128'b1);
    op_a = ~a; op_b = ~b;
    for (int i = 0; i < 3; i++) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3 * LAT; i++) begin
      if (done) begin
        pulses++;
        chk("R7 first operands", prod, gf_ref(a, b));
        chk("R7 busy clear", {127'b0, busy}, 128'b0);
      end
      @(negedge clk);
    end
    chk("R7 one done", 128'(pulses), 128'd1);
    held = prod;
    op_a = '1; op_b = '1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R8 prod held", prod, held);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd91));
    @(negedge clk);
    t_reset();
    t_zero();
    t_identity();
    t_poly();
    t_random();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule